// File: doc/BRIEF.md
# Transmit Backoff and Spacing Scheduler

This block decides the cycle in which a queued transmit packet may go onto the wire. When a packet is handed over, its contention load starts at zero. On every attempt the load is doubled and incremented. A 16-bit linear congruential generator supplies eight random bits, and these are masked with the old load to give a backoff in 32 us units. When that masked backoff is zero, the block instead enforces a minimum gap. The gap is measured from the end of the last transmission that finished cleanly. It is taken from an internal timestamp that advances once every two 16 us ticks.

Waiting is counted in 16 us ticks, which arrive on a one-cycle enable input. When the count runs out, `start` pulses for one cycle. The data mover then reports one of three outcomes: clean completion, a collision abort, or another kind of abort. A collision pulses a transmitter reset and schedules a retry with the grown load. Clean completion and non-collision aborts both post a completion code. An attempt that finds the load saturated is abandoned with a load-overflow code.

The controller is a state machine with these states:
- `BK_IDLE`: waiting for a packet.
- `BK_ATTEMPT`: updates the load, steps the generator and picks the wait.
- `BK_WAIT`: counts ticks.
- `BK_LAUNCH`: pulses `start`.
- `BK_TXING`: waits for the outcome.
- `BK_RECOVER`: pulses `tx_reset`.
- `BK_FINISH`: pulses `complete`.

Its transitions are:
- IDLE→ATTEMPT on `pkt_load`.
- ATTEMPT→FINISH on overflow.
- ATTEMPT→LAUNCH when no wait is needed.
- ATTEMPT→WAIT otherwise.
- WAIT→LAUNCH on the last tick.
- LAUNCH→TXING.
- TXING→RECOVER on a collision.
- TXING→FINISH on done or another abort.
- RECOVER→ATTEMPT.
- FINISH→IDLE.

Top module: `txbk_sched`

## Requirements
- R1: During and right after reset, `start`, `tx_reset` and `complete` are low, `busy` is low, and the generator state, load, timestamp and recorded end time are all zero.
- R2: A `pkt_load` pulse accepted in idle clears the load to 0, so the first attempt never has a random wait and always goes through the gap rule.
- R3: Each attempt whose old load has bit 15 clear stores the new load (old<<1)|1. An attempt whose old load has bit 15 set does not start, and completes with code 0x0300. For a packet that collides every time, this happens on the 17th attempt.
- R4: Every attempt, including an overflowing one, steps the generator once: R = (R*2053 + 13849) mod 2^16. The wait in 32 us units is the new R[15:8] ANDed with old load[7:0]. A nonzero value gives a wait of twice that many ticks.
- R5: When the masked wait is zero, elapsed = (timestamp − end time) mod 2^16. The packet starts without waiting if elapsed ≥ `min_gap`; otherwise it waits 2*(`min_gap` − elapsed) ticks.
- R6: `start` is a single-cycle pulse. Without a wait it is high in the second cycle after the `pkt_load` cycle. With a wait of N ticks it is high in the cycle after the N-th tick and low before that.
- R7: The timestamp advances on every second tick after reset. The end time is captured only on clean completion. If that completion coincides with a timestamp advance, the value from before the advance is kept.
- R8: `tx_abort` with `tx_collision` during transmission gives one `tx_reset` pulse and no completion. It is followed by a new attempt that keeps the load.
- R9: `tx_done`, or `tx_abort` without collision, during transmission gives one `complete` pulse with code 0x0100 | `tx_status`. An abort does not update the end time.
- R10: `tx_done` and `tx_abort` are ignored outside transmission, and `pkt_load` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable marking each 16 us tick |
| pkt_load | input | 1 | A new packet is queued |
| min_gap | input | 16 | Minimum spacing after a clean transmission, 32 us units |
| tx_done | input | 1 | Transmission finished cleanly |
| tx_abort | input | 1 | Transmission aborted |
| tx_collision | input | 1 | Qualifies an abort as a collision |
| tx_status | input | 8 | Hardware status bits for the completion code |
| start | output | 1 | Begin transmitting now |
| tx_reset | output | 1 | Reset the transmitter after a collision |
| complete | output | 1 | Completion code valid |
| complete_code | output | 16 | 0x0100 or 0x0300 plus status bits |
| busy | output | 1 | A packet is being handled |

## Verification
Capture of the end time on a clean completion can land in the same cycle as a timestamp advance. The bench provokes this by issuing ticks during transmission until the half-step phase is odd, then raising `tx_done` together with `tick`. It judges the result through the next packet's gap wait: with a minimum gap of 2, a pre-advance capture leaves an elapsed time of 1 and therefore a wait of exactly two ticks. Random waits and the gap rule are swept over a grid of gaps and idle times, and along a chain of sixteen collisions, against an arithmetic model of the generator and the load.

// File: rtl/txbk_pkg.sv
package txbk_pkg;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_ATTEMPT,
        BK_WAIT,
        BK_LAUNCH,
        BK_TXING,
        BK_RECOVER,
        BK_FINISH
    } bk_state_e;

    localparam logic [15:0] CODE_DONE     = 16'h0100;
    localparam logic [15:0] CODE_LOAD_OVF = 16'h0300;

endpackage

// File: rtl/txbk_lcg.sv
module txbk_lcg #(
    parameter int W      = 16,
    parameter int OUT_W  = 8,
    parameter int MUL    = 2053,
    parameter int ADD    = 13849
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] rand_hi
);
    localparam logic [W-1:0] MUL_W = W'(MUL);
    localparam logic [W-1:0] ADD_W = W'(ADD);

    logic [W-1:0] cur_q;
    logic [W-1:0] nxt;

    // next value is visible in the stepping cycle
    assign nxt     = cur_q * MUL_W + ADD_W;
    assign rand_hi = nxt[W-1 -: OUT_W];

    always_ff @(posedge clk) begin
        if (!rst_n)    cur_q <= '0;
        else if (step) cur_q <= nxt;
    end

    // R4: generator only moves on an attempt
    p_rng_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur_q));

endmodule

// File: rtl/txbk_timebase.sv
module txbk_timebase #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            capture,
    output logic [TS_W-1:0] elapsed
);
    logic            phase_q;
    logic [TS_W-1:0] ts_q;
    logic [TS_W-1:0] end_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            ts_q    <= '0;
        end else if (tick) begin
            phase_q <= ~phase_q;
            if (phase_q) ts_q <= ts_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       end_q <= '0;
        else if (capture) end_q <= ts_q;
    end

    assign elapsed = ts_q - end_q;

    // R7: timestamp moves once per pair of ticks
    p_ts_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase_q) |=> (ts_q == $past(ts_q) + 1'b1));

    p_ts_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ts_q));

    // R7: captured end time is the pre-advance timestamp
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (end_q == $past(ts_q)));

endmodule

// File: rtl/txbk_countdown.sv
module txbk_countdown #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             active,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_en)
            cnt_q <= load_val;
        else if (active && tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = active && tick && (cnt_q == CNT_W'(1));

    // R6: one tick consumes exactly one count
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !load_en && cnt_q > CNT_W'(1)) |=>
        (cnt_q == $past(cnt_q) - 1'b1));

    p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(active && tick)) |=> $stable(cnt_q));

endmodule

// File: rtl/txbk_sched.sv
module txbk_sched
    import txbk_pkg::*;
#(
    parameter int LOAD_W  = 16,
    parameter int RAND_W  = 8,
    parameter int RNG_W   = 16,
    parameter int TS_W    = 16,
    parameter int STAT_W  = 8,
    parameter int CODE_W  = 16,
    parameter int LCG_MUL = 2053,
    parameter int LCG_ADD = 13849
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pkt_load,
    input  logic [TS_W-1:0]   min_gap,
    input  logic              tx_done,
    input  logic              tx_abort,
    input  logic              tx_collision,
    input  logic [STAT_W-1:0] tx_status,
    output logic              start,
    output logic              tx_reset,
    output logic              complete,
    output logic [CODE_W-1:0] complete_code,
    output logic              busy
);
    localparam int BASE_W = (TS_W > RAND_W) ? TS_W : RAND_W;
    localparam int CNT_W  = BASE_W + 1;

    bk_state_e state_q, state_d;

    logic [LOAD_W-1:0] load_q;
    logic [CODE_W-1:0] code_q;
    logic [RAND_W-1:0] rand_hi;
    logic [RAND_W-1:0] masked;
    logic [TS_W-1:0]   elapsed;
    logic [TS_W-1:0]   shortfall;
    logic [CNT_W-1:0]  wait_ticks;
    logic              load_ovf;
    logic              go_now;
    logic              expire;
    logic              in_attempt;
    logic              capture;
    logic              finish_tx;
    logic              collide;

    assign in_attempt = (state_q == BK_ATTEMPT);
    assign load_ovf   = load_q[LOAD_W-1];
    assign collide    = (state_q == BK_TXING) && tx_abort && tx_collision;
    assign finish_tx  = (state_q == BK_TXING) && !collide && (tx_abort || tx_done);
    assign capture    = (state_q == BK_TXING) && tx_done && !tx_abort;

    txbk_lcg #(
        .W     (RNG_W),
        .OUT_W (RAND_W),
        .MUL   (LCG_MUL),
        .ADD   (LCG_ADD)
    ) u_lcg (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_attempt),
        .rand_hi (rand_hi)
    );

    txbk_timebase #(
        .TS_W (TS_W)
    ) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .capture (capture),
        .elapsed (elapsed)
    );

    // wait selection: random backoff first, gap rule when it is zero
    always_comb begin
        masked    = rand_hi & load_q[RAND_W-1:0];
        shortfall = (elapsed >= min_gap) ? '0 : (min_gap - elapsed);
        if (masked != '0)
            wait_ticks = CNT_W'({masked, 1'b0});
        else
            wait_ticks = CNT_W'({shortfall, 1'b0});
        go_now = (wait_ticks == '0);
    end

    txbk_countdown #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (in_attempt),
        .load_val (wait_ticks),
        .active   (state_q == BK_WAIT),
        .tick     (tick),
        .expire   (expire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE:    if (pkt_load) state_d = BK_ATTEMPT;
            BK_ATTEMPT: begin
                if (load_ovf)    state_d = BK_FINISH;
                else if (go_now) state_d = BK_LAUNCH;
                else             state_d = BK_WAIT;
            end
            BK_WAIT:    if (expire) state_d = BK_LAUNCH;
            BK_LAUNCH:  state_d = BK_TXING;
            BK_TXING: begin
                if (collide)        state_d = BK_RECOVER;
                else if (finish_tx) state_d = BK_FINISH;
            end
            BK_RECOVER: state_d = BK_ATTEMPT;
            BK_FINISH:  state_d = BK_IDLE;
            default:    state_d = BK_IDLE;
        endcase
    end

    // per-packet load and completion code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            code_q <= '0;
        end else begin
            if (state_q == BK_IDLE && pkt_load)
                load_q <= '0;
            else if (in_attempt && !load_ovf)
                load_q <= {load_q[LOAD_W-2:0], 1'b1};

            if (in_attempt && load_ovf)
                code_q <= CODE_LOAD_OVF;
            else if (finish_tx)
                code_q <= CODE_DONE | CODE_W'(tx_status);
        end
    end

    // outputs
    always_comb begin
        start         = (state_q == BK_LAUNCH);
        tx_reset      = (state_q == BK_RECOVER);
        complete      = (state_q == BK_FINISH);
        busy          = (state_q != BK_IDLE);
        complete_code = code_q;
    end

    // R3: load grows by doubling plus one
    p_load_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_attempt && !load_ovf) |=>
        (load_q == {$past(load_q[LOAD_W-2:0]), 1'b1}));

    // R3: saturated load ends the packet with the overflow code
    p_no_overflow_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_attempt && load_ovf) |=>
        (complete && !start && complete_code == CODE_LOAD_OVF));

    // R6: start lasts a single cycle
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R8: a collision reset is followed by a fresh attempt
    p_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> (in_attempt && !complete));

    // R10: completion inputs have no effect in idle
    p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_IDLE && !pkt_load) |=> !busy);

endmodule

// File: tb/tb_txbk_sched.sv
module tb_txbk_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pkt_load = 1'b0;
    logic [15:0] min_gap = '0;
    logic        tx_done = 1'b0;
    logic        tx_abort = 1'b0;
    logic        tx_collision = 1'b0;
    logic [7:0]  tx_status = '0;
    logic        start, tx_reset, complete, busy;
    logic [15:0] complete_code;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [15:0] m_rng = '0;
    logic [15:0] m_load = '0;
    logic [15:0] m_ts = '0;
    logic [15:0] m_last = '0;
    logic        m_phase = 1'b0;
    logic [15:0] m_gap = '0;

    always #10 clk = ~clk;

    txbk_sched dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pkt_load(pkt_load),
        .min_gap(min_gap), .tx_done(tx_done), .tx_abort(tx_abort),
        .tx_collision(tx_collision), .tx_status(tx_status),
        .start(start), .tx_reset(tx_reset), .complete(complete),
        .complete_code(complete_code), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick_once();
        tick = 1'b1;
        @(posedge clk);
        if (m_phase) m_ts = m_ts + 16'd1;
        m_phase = ~m_phase;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // called at a negedge with the design in the attempt state
    task automatic decide(input string ctx, output bit ovf);
        logic [15:0] old;
        logic [15:0] el;
        logic [7:0]  w;
        int          n;
        old   = m_load;
        m_rng = m_rng * 16'd2053 + 16'd13849;
        if (old[15]) begin
            @(posedge clk); @(negedge clk);
            chk(complete && complete_code == 16'h0300, {ctx, " R3 overflow code"},
                complete_code, 16'h0300);
            chk(!start, {ctx, " R3 no start on overflow"}, start, 0);
            ovf = 1'b1;
            return;
        end
        ovf    = 1'b0;
        m_load = {old[14:0], 1'b1};
        w      = m_rng[15:8] & old[7:0];
        if (w != 0) begin
            n = 2 * int'(w);
        end else begin
            el = m_ts - m_last;
            n  = (el >= m_gap) ? 0 : 2 * (int'(m_gap) - int'(el));
        end
        @(posedge clk); @(negedge clk);
        if (n == 0) begin
            chk(start, {ctx, " R5 R6 immediate start"}, start, 1);
        end else begin
            chk(!start, {ctx, " R4 R5 no early start"}, start, 0);
            repeat (n - 1) tick_once();
            chk(!start, {ctx, " R6 start held until last tick"}, start, 0);
            tick_once();
            chk(start, {ctx, " R6 start after final tick"}, start, 1);
        end
        @(posedge clk); @(negedge clk);
        chk(!start, {ctx, " R6 start single pulse"}, start, 0);
    endtask

    task automatic new_packet();
        pkt_load = 1'b1;
        @(posedge clk); @(negedge clk);
        pkt_load = 1'b0;
        m_load = '0; // R2
        chk(busy, "R2 busy after load", busy, 1);
    endtask

    task automatic collide();
        tx_abort = 1'b1; tx_collision = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_abort = 1'b0; tx_collision = 1'b0;
        chk(tx_reset && !complete, "R8 reset pulse on collision", tx_reset, 1);
        @(posedge clk); @(negedge clk);
        chk(!tx_reset, "R8 reset single pulse", tx_reset, 0);
    endtask

    task automatic finish_done(input logic [7:0] st, input bit with_tick);
        tx_done = 1'b1; tx_status = st; tick = with_tick;
        @(posedge clk);
        m_last = m_ts;
        if (with_tick) begin
            if (m_phase) m_ts = m_ts + 16'd1;
            m_phase = ~m_phase;
        end
        @(negedge clk);
        tx_done = 1'b0; tick = 1'b0;
        chk(complete && complete_code == (16'h0100 | st), "R9 done code",
            complete_code, 16'h0100 | st);
        @(posedge clk); @(negedge clk);
        chk(!busy && !complete, "R9 back to idle", busy, 0);
    endtask

    task automatic finish_abort(input logic [7:0] st);
        tx_abort = 1'b1; tx_collision = 1'b0; tx_status = st;
        @(posedge clk); @(negedge clk);
        tx_abort = 1'b0;
        chk(complete && !tx_reset && complete_code == (16'h0100 | st),
            "R9 abort code", complete_code, 16'h0100 | st);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ovf;
        int coll;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!start && !tx_reset && !complete && !busy, "R1 outputs low in reset",
            {start, tx_reset, complete, busy}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!busy && complete_code == 0, "R1 idle after reset", busy, 0);

        // R10: completion inputs in idle
        tx_done = 1'b1; tx_abort = 1'b1; tx_collision = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_done = 1'b0; tx_abort = 1'b0; tx_collision = 1'b0;
        chk(!complete && !tx_reset && !busy, "R10 idle ignores outcomes",
            {complete, tx_reset, busy}, 0);

        // R5 sweep: gap versus idle time, first attempts only (R2)
        for (int g = 0; g < 5; g++) begin
            for (int a = 0; a < 6; a++) begin
                m_gap = 16'(g); min_gap = 16'(g);
                repeat (a) tick_once();
                new_packet();
                decide("R2 sweep", ovf);
                finish_done(8'(g * 16 + a), 1'b0);
            end
        end

        // R3 R4 R8: collision chain up to load overflow
        m_gap = 16'd3; min_gap = 16'd3;
        new_packet();
        decide("R4 chain", ovf);
        // R10: a new packet request while busy must not clear the load
        pkt_load = 1'b1;
        @(posedge clk); @(negedge clk);
        pkt_load = 1'b0;
        coll = 0;
        ovf = 1'b0;
        while (!ovf && coll < 20) begin
            collide();
            coll++;
            decide("R4 R10 chain", ovf);
        end
        chk(coll == 16, "R3 overflow on 17th attempt", coll, 16);
        @(posedge clk); @(negedge clk);
        chk(!busy, "R3 idle after overflow", busy, 0);

        // R9 R7: non-collision abort keeps old end time
        m_gap = 16'd6; min_gap = 16'd6;
        new_packet();
        decide("R9 pre-abort", ovf);
        finish_abort(8'h5A);
        new_packet();
        decide("R7 after abort", ovf);
        finish_done(8'h11, 1'b0);

        // R7: completion coinciding with a timestamp advance
        m_gap = 16'd2; min_gap = 16'd2;
        new_packet();
        decide("R7 pre-coincide", ovf);
        tick_once();
        if (!m_phase) tick_once();
        finish_done(8'h33, 1'b1);
        new_packet();
        decide("R7 coincident capture", ovf);
        finish_done(8'h44, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule